// File: doc/BRIEF.md
# Integer Execute Unit with Instruction Decode

This block is the combinational execute stage of a 32-bit integer pipeline. It receives a raw instruction word together with the two source register values already read from the register file. It decodes the opcode, the 3-bit and 7-bit function fields and, for immediate forms, the 12-bit immediate. It then produces the value to be written back and a write strobe for the destination register.

Two instruction classes are handled: register-register operations and register-immediate operations. Each class covers add, subtract, the three logical operations, the three shift kinds, and signed and unsigned set-less-than. Any other encoding is flagged as illegal, and the write strobe is held low.

The block has no internal state. It has no clock or reset, so its three outputs follow the inputs within the same cycle. Because there are no states, the house state-machine layout reduces to two processes: one names the decoded operation, and one selects the output from it.

Top module: `rv_int_exec`

## Requirements
- R1: Opcode 7'b0110011 (instr[6:0]) selects the register-register form, with operand B taken from rs2_val. Opcode 7'b0010011 selects the immediate form, with operand B equal to instr[31:20] sign-extended to 32 bits.
- R2: funct3 (instr[14:12]) selects the operation: 000 add, 001 shift left, 010 signed less-than, 011 unsigned less-than, 100 XOR, 101 shift right, 110 OR, 111 AND.
- R3: In the register form, funct7 (instr[31:25]) equal to 0100000 with funct3 000 yields A minus B, modulo 2^32.
- R4: The shift amount is operand B bits [4:0], which is rs2_val[4:0] in the register form and instr[24:20] in the immediate form. Left shifts and logical right shifts fill with zeros.
- R5: funct7 0100000 with funct3 101 gives an arithmetic right shift that fills with bit 31 of operand A, in both forms.
- R6: Signed less-than compares two's-complement values, and unsigned less-than compares raw values; the result is 1 or 0. The immediate unsigned compare uses the sign-extended immediate.
- R7: For immediate add (funct3 000), instr[30] is part of the immediate and never selects subtraction.
- R8: The encoding is illegal, with illegal=1, rd_wen=0 and result=0, in any of these cases: an opcode other than the two above; a register-form funct7 other than 0000000 or 0100000; register-form funct7 0100000 with funct3 other than 000 or 101; an immediate shift-left with funct7 other than 0000000; an immediate shift-right with funct7 other than 0000000 or 0100000.
- R9: When rd (instr[11:7]) is 0, rd_wen is 0 even for a legal instruction, while result still carries the computed value.
- R10: A legal instruction with nonzero rd drives rd_wen=1 and illegal=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word to decode |
| rs1_val | input | 32 | First source register value (operand A) |
| rs2_val | input | 32 | Second source register value |
| result | output | 32 | Computed write-back value, zero when illegal |
| rd_wen | output | 1 | Destination register write strobe |
| illegal | output | 1 | Encoding not recognised by this unit |

## Verification
The checks inside the design are immediate checks. They are evaluated only when the operands they read are free of X or Z, so they take for granted that the surrounding pipeline presents fully known instruction and operand values whenever the outputs are consumed. The stimulus holds every input at a defined value from the first clock onward. It changes inputs only on the falling clock edge, so each check sees settled, known operands. The vectors include shift amounts with upper bits set in rs2_val and immediates with bit 11 or bit 10 set, so that operand-selection and sign-extension faults appear at the result port.

// File: rtl/rv_exec_pkg.sv
package rv_exec_pkg;

    localparam int XLEN = 32;
    localparam int SHW  = $clog2(XLEN);

    localparam logic [6:0] OPC_REG = 7'b0110011;
    localparam logic [6:0] OPC_IMM = 7'b0010011;
    localparam logic [6:0] F7_BASE = 7'b0000000;
    localparam logic [6:0] F7_ALT  = 7'b0100000;

    typedef enum logic [3:0] {
        OP_ADD,
        OP_SUB,
        OP_SLL,
        OP_SLT,
        OP_SLTU,
        OP_XOR,
        OP_SRL,
        OP_SRA,
        OP_OR,
        OP_AND
    } exec_op_e;

    typedef enum logic [1:0] {
        SH_LEFT,
        SH_RIGHT_LOG,
        SH_RIGHT_ARI
    } shift_kind_e;

    typedef struct packed {
        exec_op_e   op;
        logic       use_imm;
        logic       legal;
        logic [4:0] rd;
    } dec_word_t;

endpackage

// File: rtl/rv_exec_decode.sv
module rv_exec_decode
    import rv_exec_pkg::*;
(
    input  logic [6:0] opcode,
    input  logic [2:0] funct3,
    input  logic [6:0] funct7,
    input  logic [4:0] rd_idx,
    output dec_word_t  dec
);

    logic is_reg;
    logic is_imm;
    logic f7_base;
    logic f7_alt;
    logic alt_sel;

    always_comb begin
        is_reg  = (opcode == OPC_REG);
        is_imm  = (opcode == OPC_IMM);
        f7_base = (funct7 == F7_BASE);
        f7_alt  = (funct7 == F7_ALT);
        alt_sel = 1'b0;
        dec.legal   = 1'b0;
        dec.use_imm = is_imm;
        dec.rd      = rd_idx;

        if (is_reg) begin
            unique case (funct3)
                3'b000, 3'b101: begin
                    dec.legal = f7_base | f7_alt;
                    alt_sel   = f7_alt;
                end
                default: dec.legal = f7_base;
            endcase
        end else if (is_imm) begin
            unique case (funct3)
                3'b001: dec.legal = f7_base;
                3'b101: begin
                    dec.legal = f7_base | f7_alt;
                    alt_sel   = f7_alt;
                end
                default: dec.legal = 1'b1;
            endcase
        end

        unique case (funct3)
            3'b000:  dec.op = (alt_sel && is_reg) ? OP_SUB : OP_ADD;
            3'b001:  dec.op = OP_SLL;
            3'b010:  dec.op = OP_SLT;
            3'b011:  dec.op = OP_SLTU;
            3'b100:  dec.op = OP_XOR;
            3'b101:  dec.op = alt_sel ? OP_SRA : OP_SRL;
            3'b110:  dec.op = OP_OR;
            default: dec.op = OP_AND;
        endcase
    end

    always_comb begin
        if (!$isunknown({opcode, funct7, funct3})) begin
            p_foreign_opcode_r8: assert (is_reg || is_imm || !dec.legal)
                else $error("decode accepted a foreign opcode");
        end
    end

endmodule

// File: rtl/rv_exec_shift.sv
module rv_exec_shift
    import rv_exec_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int AW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [AW-1:0] amt,
    input  shift_kind_e   kind,
    output logic [W-1:0]  dout
);

    always_comb begin
        unique case (kind)
            SH_LEFT:      dout = din << amt;
            SH_RIGHT_ARI: dout = W'($signed(din) >>> amt);
            default:      dout = din >> amt;
        endcase
    end

    always_comb begin
        if (!$isunknown({din, amt, kind})) begin
            p_zero_amount_r4: assert (amt != '0 || dout == din)
                else $error("shift by zero altered the operand");
            p_sign_fill_r5: assert (kind != SH_RIGHT_ARI || dout[W-1] == din[W-1])
                else $error("arithmetic shift lost the sign bit");
        end
    end

endmodule

// File: rtl/rv_exec_compare.sv
module rv_exec_compare
    import rv_exec_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         lt_signed,
    output logic         lt_unsigned
);

    always_comb begin
        lt_unsigned = (a < b);
        lt_signed   = ($signed(a) < $signed(b));
    end

    always_comb begin
        if (!$isunknown({a, b})) begin
            p_split_needs_sign_r6: assert ((lt_signed == lt_unsigned) || (a[W-1] != b[W-1]))
                else $error("signed and unsigned compare differ with equal signs");
        end
    end

endmodule

// File: rtl/rv_int_exec.sv
module rv_int_exec
    import rv_exec_pkg::*;
(
    input  logic [31:0] instr,
    input  logic [31:0] rs1_val,
    input  logic [31:0] rs2_val,
    output logic [31:0] result,
    output logic        rd_wen,
    output logic        illegal
);

    localparam int IMMW = 12;

    dec_word_t      dec;
    logic [XLEN-1:0] opb;
    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] sh_out;
    logic [XLEN-1:0] sum_out;
    logic            lt_s;
    logic            lt_u;
    shift_kind_e     sh_kind;
    logic            unused_rs1_field;

    assign unused_rs1_field = ^instr[19:15];

    rv_exec_decode u_dec (
        .opcode (instr[6:0]),
        .funct3 (instr[14:12]),
        .funct7 (instr[31:25]),
        .rd_idx (instr[11:7]),
        .dec    (dec)
    );

    always_comb begin
        imm_ext = {{(XLEN-IMMW){instr[31]}}, instr[31:20]};
        opb     = dec.use_imm ? imm_ext : rs2_val;
        sum_out = (dec.op == OP_SUB) ? (rs1_val - opb) : (rs1_val + opb);
        unique case (dec.op)
            OP_SLL:  sh_kind = SH_LEFT;
            OP_SRA:  sh_kind = SH_RIGHT_ARI;
            default: sh_kind = SH_RIGHT_LOG;
        endcase
    end

    rv_exec_shift #(.W(XLEN)) u_shift (
        .din  (rs1_val),
        .amt  (opb[SHW-1:0]),
        .kind (sh_kind),
        .dout (sh_out)
    );

    rv_exec_compare #(.W(XLEN)) u_cmp (
        .a           (rs1_val),
        .b           (opb),
        .lt_signed   (lt_s),
        .lt_unsigned (lt_u)
    );

    always_comb begin
        illegal = !dec.legal;
        rd_wen  = dec.legal && (dec.rd != 5'd0);
        result  = '0;
        if (dec.legal) begin
            unique case (dec.op)
                OP_ADD, OP_SUB:         result = sum_out;
                OP_SLL, OP_SRL, OP_SRA: result = sh_out;
                OP_SLT:                 result = {{(XLEN-1){1'b0}}, lt_s};
                OP_SLTU:                result = {{(XLEN-1){1'b0}}, lt_u};
                OP_XOR:                 result = rs1_val ^ opb;
                OP_OR:                  result = rs1_val | opb;
                default:                result = rs1_val & opb;
            endcase
        end
    end

    always_comb begin
        if (!$isunknown({instr, rs1_val, rs2_val})) begin
            p_illegal_no_write_r8: assert (!illegal || (!rd_wen && result == '0))
                else $error("illegal encoding produced a write");
            p_rd_zero_no_write_r9: assert (instr[11:7] != 5'd0 || !rd_wen)
                else $error("write strobe raised for rd zero");
            p_compare_is_bit_r6: assert (illegal || !(instr[14:12] == 3'b010 || instr[14:12] == 3'b011)
                                         || result[XLEN-1:1] == '0)
                else $error("compare result wider than one bit");
        end
    end

endmodule

// File: tb/sim_rv_int_exec.sv
module sim_rv_int_exec;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = 32'h0;
    logic [31:0] rs1_val = 32'h0;
    logic [31:0] rs2_val = 32'h0;
    logic [31:0] result;
    logic        rd_wen;
    logic        illegal;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    rv_int_exec u0 (
        .instr   (instr),
        .rs1_val (rs1_val),
        .rs2_val (rs2_val),
        .result  (result),
        .rd_wen  (rd_wen),
        .illegal (illegal)
    );

    function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [2:0] f3, input logic [4:0] rd);
        return {f7, 5'd2, 5'd1, f3, rd, 7'b0110011};
    endfunction

    function automatic logic [31:0] enc_i(input logic [11:0] imm, input logic [2:0] f3, input logic [4:0] rd);
        return {imm, 5'd1, f3, rd, 7'b0010011};
    endfunction

    // row: {tag, instr, a, b, expected result, expected wen, expected illegal}
    localparam int NV = 26;
    localparam logic [137:0] VEC [NV] = '{
        {8'd2,  enc_r(7'h00, 3'b000, 5'd5), 32'd5,        32'd7,        32'd12,       1'b1, 1'b0}, // R2 add
        {8'd3,  enc_r(7'h20, 3'b000, 5'd5), 32'd5,        32'd7,        32'hFFFFFFFE, 1'b1, 1'b0}, // R3 sub
        {8'd2,  enc_r(7'h00, 3'b100, 5'd5), 32'hF0F0F0F0, 32'hFF00FF00, 32'h0FF00FF0, 1'b1, 1'b0}, // R2 xor
        {8'd2,  enc_r(7'h00, 3'b110, 5'd5), 32'hF0F0F0F0, 32'hFF00FF00, 32'hFFF0FFF0, 1'b1, 1'b0}, // R2 or
        {8'd2,  enc_r(7'h00, 3'b111, 5'd5), 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000, 1'b1, 1'b0}, // R2 and
        {8'd4,  enc_r(7'h00, 3'b001, 5'd5), 32'd1,        32'h24,       32'h10,       1'b1, 1'b0}, // R4 sll low bits only
        {8'd4,  enc_r(7'h00, 3'b101, 5'd5), 32'h80000000, 32'd31,       32'd1,        1'b1, 1'b0}, // R4 srl
        {8'd5,  enc_r(7'h20, 3'b101, 5'd5), 32'h80000000, 32'd4,        32'hF8000000, 1'b1, 1'b0}, // R5 sra
        {8'd6,  enc_r(7'h00, 3'b010, 5'd5), 32'hFFFFFFFF, 32'd1,        32'd1,        1'b1, 1'b0}, // R6 slt
        {8'd6,  enc_r(7'h00, 3'b011, 5'd5), 32'hFFFFFFFF, 32'd1,        32'd0,        1'b1, 1'b0}, // R6 sltu
        {8'd1,  enc_i(12'hFFF, 3'b000, 5'd5), 32'd10,     32'd0,        32'd9,        1'b1, 1'b0}, // R1 addi negative
        {8'd7,  enc_i(12'h403, 3'b000, 5'd5), 32'd0,      32'd0,        32'h403,      1'b1, 1'b0}, // R7 bit30 in imm
        {8'd6,  enc_i(12'hFFF, 3'b011, 5'd5), 32'd5,      32'd0,        32'd1,        1'b1, 1'b0}, // R6 sltiu
        {8'd6,  enc_i(12'hFFF, 3'b010, 5'd5), 32'd5,      32'd0,        32'd0,        1'b1, 1'b0}, // R6 slti
        {8'd5,  enc_i(12'h404, 3'b101, 5'd5), 32'h80000010, 32'd0,      32'hF8000001, 1'b1, 1'b0}, // R5 srai
        {8'd4,  enc_i(12'h01F, 3'b001, 5'd5), 32'd3,      32'hFFFFFFFF, 32'h80000000, 1'b1, 1'b0}, // R4 slli
        {8'd1,  enc_i(12'h800, 3'b100, 5'd5), 32'h0000FFFF, 32'd0,      32'hFFFF07FF, 1'b1, 1'b0}, // R1 xori sext
        {8'd1,  enc_i(12'h7FF, 3'b111, 5'd5), 32'hFFFFFFFF, 32'd0,      32'h000007FF, 1'b1, 1'b0}, // R1 andi
        {8'd10, enc_i(12'h123, 3'b110, 5'd9), 32'd0,      32'd0,        32'h123,      1'b1, 1'b0}, // R10 ori
        {8'd4,  enc_i(12'h01C, 3'b101, 5'd5), 32'hF0000000, 32'd1,      32'hF,        1'b1, 1'b0}, // R4 srli
        {8'd8,  32'h000012B7,                 32'd1,      32'd2,        32'd0,        1'b0, 1'b1}, // R8 other opcode
        {8'd8,  enc_r(7'h01, 3'b000, 5'd5), 32'd1,        32'd2,        32'd0,        1'b0, 1'b1}, // R8 bad funct7
        {8'd8,  enc_r(7'h20, 3'b111, 5'd5), 32'd1,        32'd2,        32'd0,        1'b0, 1'b1}, // R8 alt on and
        {8'd8,  enc_i(12'h401, 3'b001, 5'd5), 32'd1,      32'd2,        32'd0,        1'b0, 1'b1}, // R8 slli alt
        {8'd8,  enc_i(12'h025, 3'b101, 5'd5), 32'd1,      32'd2,        32'd0,        1'b0, 1'b1}, // R8 srli bad
        {8'd9,  enc_r(7'h00, 3'b000, 5'd0), 32'd1,        32'd2,        32'd3,        1'b0, 1'b0}  // R9 rd zero
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] i, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        instr   = i;
        rs1_val = a;
        rs2_val = b;
        @(posedge clk);
        #1;
    endtask

    initial begin
        fork
            begin
                repeat (4) @(posedge clk);
                rst_n = 1'b1;
                // idle state: all-zero word is not a recognised opcode (R8)
                #1;
                chk("R8 idle illegal", {31'd0, illegal}, 32'd1);
                chk("R8 idle wen", {31'd0, rd_wen}, 32'd0);
                chk("R8 idle result", result, 32'd0);

                for (int k = 0; k < NV; k++) begin
                    apply(VEC[k][129:98], VEC[k][97:66], VEC[k][65:34]);
                    chk($sformatf("R%0d row %0d result", VEC[k][137:130], k), result, VEC[k][33:2]);
                    chk($sformatf("R%0d row %0d wen", VEC[k][137:130], k), {31'd0, rd_wen}, {31'd0, VEC[k][1]});
                    chk($sformatf("R%0d row %0d illegal", VEC[k][137:130], k), {31'd0, illegal}, {31'd0, VEC[k][0]});
                end

                // R1: immediate form ignores rs2_val
                apply(enc_i(12'h004, 3'b000, 5'd3), 32'd100, 32'hDEADBEEF);
                chk("R1 imm ignores rs2", result, 32'd104);
                // R3: sub wraps
                apply(enc_r(7'h20, 3'b000, 5'd3), 32'd0, 32'd1);
                chk("R3 sub wrap", result, 32'hFFFFFFFF);
                // R5: arithmetic shift of positive value fills zeros
                apply(enc_r(7'h20, 3'b101, 5'd3), 32'h7FFFFFFF, 32'd30);
                chk("R5 sra positive", result, 32'd1);
                // R9: addi to rd zero suppressed
                apply(enc_i(12'h000, 3'b000, 5'd0), 32'd7, 32'd0);
                chk("R9 nop wen", {31'd0, rd_wen}, 32'd0);
                chk("R9 nop illegal", {31'd0, illegal}, 32'd0);
                // R10: legal write strobe with rd 31
                apply(enc_r(7'h00, 3'b011, 5'd31), 32'd1, 32'hFFFFFFFF);
                chk("R10 wen", {31'd0, rd_wen}, 32'd1);
                chk("R6 sltu large", result, 32'd1);
            end
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule